// File: doc/BRIEF.md
# MDIO Management Master (Short and Extended Addressing)

This block is the bus master for the two-wire PHY management interface. It makes the management clock (MDC) from the system clock with a programmable divider. It drives or releases the bidirectional data line (MDIO) through a separate output and output-enable pair, so the pad itself stays outside the block. A single host request produces a complete register read or write.

The host presents a PHY address, a 32-bit register argument, write data and a read/write flag, then pulses a start strobe. When bit 30 of the argument is clear, the block sends one short-address frame. When bit 30 is set, the same request expands into two frames on the bus:

- an address frame, which carries the 16-bit register offset;
- an access frame, which performs the read or write.

Both address styles can therefore share one bus. At the end of the request the block returns read data, a one-cycle done pulse and, for reads, an error flag.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 MDC cycles in which the master drives MDIO to 1.
- R2: With bit 30 of `req_arg` clear, one frame is sent. It carries, MSB first, a start of 0,1, then an opcode of 1,0 for a read or 0,1 for a write, then `req_phy[4:0]`, then `req_arg[4:0]`. All other bits of `req_arg` have no effect.
- R3: With bit 30 of `req_arg` set, an address frame is sent first. Its fields are start 0,0, opcode 0,0, `req_phy`, then `req_arg[20:16]`, then turnaround 1,0 and `req_arg[15:0]`. One extra MDC cycle follows with MDIO released. Then an access frame is sent with start 0,0, opcode 1,1 for a read or 0,1 for a write, `req_phy` and `req_arg[20:16]`. Bits 31 and 29:21 of `req_arg` have no effect.
- R4: In a write frame, the master drives the turnaround as 1,0 and then `req_wdata` MSB first.
- R5: In a read frame, `mdio_oe` is low from the first turnaround bit until the frame ends. The 16 data bits are sampled on rising MDC edges, MSB first. They are returned on `rdata` in the cycle where `done` is high, with `err` low.
- R6: If the second turnaround bit of a read is sampled as 1, the frame still runs to its full length. In that case `done` comes with `err` high and `rdata` equal to 16'hFFFF.
- R7: MDC spends `DIV_HALF` clocks high and `DIV_HALF` clocks low, and stays low outside transactions. `mdio_o` changes only while MDC is low. A short-address request takes exactly 64 MDC cycles and an extended request exactly 129.
- R8: `busy` stays high from the cycle after an accepted start until `done`. A start strobe while `busy` is high has no effect. `done` is a single-cycle pulse per request.
- R9: After reset, `mdc`, `mdio_oe`, `busy`, `done` and `err` are low. `mdio_oe` is low outside transactions and high for every bit the master drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start strobe, accepted only while idle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_arg | input | 32 | Register argument; bit 30 selects extended addressing |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Read turnaround error, valid with done |
| rdata | output | 16 | Read data, valid with done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The bench steps PHY addresses, register numbers, device IDs, offsets and data through all four request kinds. These are short-address and extended addressing, each as a read and as a write, and include the all-zeros and all-ones field values. For each request it compares the full captured bit stream and the output-enable pattern against frames built arithmetically.

This comparison separates several kinds of fault:
- an opcode or start swap between the two addressing styles;
- a misplaced field or a wrong bit order;
- a missing idle bit between the two extended frames;
- turnaround bits that are driven when they should be released.

Arguments with the ignored upper bits set show that only bit 30 selects the frame style. A PHY model that drives a bad turnaround bit exercises the error path. A second start strobe issued in the middle of a transfer shows that the request is dropped rather than queued.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int PHY_W      = 5;
  localparam int FLD_W      = 5;
  localparam int DATA_W     = 16;
  localparam int ARG_W      = 32;
  localparam int EXT_BIT    = 30;
  localparam int DEV_LO     = 16;
  localparam int TA_IDX     = PRE_BITS + 4 + PHY_W + FLD_W;
  localparam int DATA_IDX   = TA_IDX + 2;
  localparam int FRAME_BITS = DATA_IDX + DATA_W;

  localparam logic [1:0] OP_SHORT_RD = 2'b10;
  localparam logic [1:0] OP_SHORT_WR = 2'b01;
  localparam logic [1:0] OP_EXT_ADR  = 2'b00;
  localparam logic [1:0] OP_EXT_WR   = 2'b01;
  localparam logic [1:0] OP_EXT_RD   = 2'b11;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_ACC} phase_t;

  // Whole frame, MSB first: preamble, start, opcode, phy, field, turnaround, data.
  function automatic logic [FRAME_BITS-1:0] make_word(
      input logic ext, input logic [1:0] op, input logic [PHY_W-1:0] phy,
      input logic [FLD_W-1:0] fld, input logic [DATA_W-1:0] d);
    return {{PRE_BITS{1'b1}}, 1'b0, ~ext, op, phy, fld, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_now,
  output logic fall_now
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = en && (cnt == CW'(DIV_HALF - 1));
  assign rise_now = wrap && !mdc;
  assign fall_now = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: a stopped divider leaves MDC low
  a_r7_stop_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NBITS-1:0] word,
  input  logic             rd,
  input  logic             extra_idle,
  input  logic             mdc,
  input  logic             rise_now,
  input  logic             fall_now,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             fin,
  output logic             ta_bad,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IW = $clog2(NBITS + 2);

  logic             active, rd_q, xtra_q;
  logic [IW-1:0]    idx, nxt, last;
  logic [NBITS-1:0] sh;

  assign nxt  = idx + 1'b1;
  assign last = xtra_q ? IW'(NBITS) : IW'(NBITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      xtra_q  <= 1'b0;
      idx     <= '0;
      sh      <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      fin     <= 1'b0;
      ta_bad  <= 1'b0;
      rd_data <= '0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          idx     <= '0;
          sh      <= word << 1;
          mdio_o  <= word[NBITS-1];
          mdio_oe <= 1'b1;
          rd_q    <= rd;
          xtra_q  <= extra_idle;
          ta_bad  <= 1'b0;
          rd_data <= '0;
        end
      end else begin
        if (rise_now && rd_q) begin
          if (idx == IW'(TA_IDX + 1)) ta_bad <= mdio_i;
          if (idx >= IW'(DATA_IDX) && idx < IW'(NBITS))
            rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        end
        if (fall_now) begin
          if (idx == last) begin
            active  <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            fin     <= 1'b1;
          end else begin
            idx     <= nxt;
            mdio_o  <= sh[NBITS-1];
            sh      <= sh << 1;
            mdio_oe <= !((nxt >= IW'(NBITS)) || (rd_q && nxt >= IW'(TA_IDX)));
          end
        end
      end
    end
  end

  // R1: preamble bits are driven ones
  a_r1_preamble_ones: assert property (@(posedge clk) disable iff (rst)
    (active && idx < IW'(PRE_BITS)) |-> (mdio_oe && mdio_o));
  // R5: line released from the turnaround on in read frames
  a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
    (active && rd_q && idx >= IW'(TA_IDX)) |-> !mdio_oe);
  // R7: output value only moves while MDC is low
  a_r7_change_mdc_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_rd,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [ARG_W-1:0]  req_arg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  phase_t                ph;
  logic                  go, fr_rd, fr_xtra, fin, ta_bad;
  logic [FRAME_BITS-1:0] word;
  logic                  rd_q;
  logic [PHY_W-1:0]      phy_q;
  logic [FLD_W-1:0]      dev_q;
  logic [DATA_W-1:0]     wd_q, eng_rd;
  logic                  rise_now, fall_now;
  logic                  arg_unused;

  assign arg_unused = ^{req_arg[ARG_W-1:EXT_BIT+1], req_arg[EXT_BIT-1:DEV_LO+FLD_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
      go      <= 1'b0;
      word    <= '0;
      fr_rd   <= 1'b0;
      fr_xtra <= 1'b0;
      rd_q    <= 1'b0;
      phy_q   <= '0;
      dev_q   <= '0;
      wd_q    <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
      unique case (ph)
        PH_IDLE: if (req_start) begin
          busy  <= 1'b1;
          go    <= 1'b1;
          rd_q  <= req_rd;
          phy_q <= req_phy;
          dev_q <= req_arg[DEV_LO +: FLD_W];
          wd_q  <= req_wdata;
          if (req_arg[EXT_BIT]) begin
            ph      <= PH_ADDR;
            word    <= make_word(1'b1, OP_EXT_ADR, req_phy, req_arg[DEV_LO +: FLD_W],
                                 req_arg[DATA_W-1:0]);
            fr_rd   <= 1'b0;
            fr_xtra <= 1'b1;
          end else begin
            ph      <= PH_ACC;
            word    <= make_word(1'b0, req_rd ? OP_SHORT_RD : OP_SHORT_WR, req_phy,
                                 req_arg[FLD_W-1:0], req_wdata);
            fr_rd   <= req_rd;
            fr_xtra <= 1'b0;
          end
        end
        PH_ADDR: if (fin) begin
          ph      <= PH_ACC;
          go      <= 1'b1;
          word    <= make_word(1'b1, rd_q ? OP_EXT_RD : OP_EXT_WR, phy_q, dev_q, wd_q);
          fr_rd   <= rd_q;
          fr_xtra <= 1'b0;
        end
        PH_ACC: if (fin) begin
          ph   <= PH_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
          if (rd_q) begin
            err   <= ta_bad;
            rdata <= ta_bad ? '1 : eng_rd;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) clk_i (
    .clk(clk), .rst(rst), .en(busy),
    .mdc(mdc), .rise_now(rise_now), .fall_now(fall_now)
  );

  mdio_frame_eng #(.NBITS(FRAME_BITS)) eng_i (
    .clk(clk), .rst(rst), .go(go), .word(word), .rd(fr_rd), .extra_idle(fr_xtra),
    .mdc(mdc), .rise_now(rise_now), .fall_now(fall_now), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .fin(fin), .ta_bad(ta_bad), .rd_data(eng_rd)
  );

  // R8: done is a single pulse and marks the end of busy
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6: error only reported together with done
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R9: line released and clock low outside transactions
  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  a_r7_idle_mdc_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0, req_rd = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [31:0] req_arg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rdata;

  int n_chk = 0, n_fail = 0;

  // PHY model state
  logic         phy_en = 1'b0, phy_bit = 1'b1;
  int           rise_total = 0, t_base = 0;
  logic         t_ext = 1'b0, t_rd = 1'b0, t_ta = 1'b0;
  logic [15:0]  t_rdv = '0;
  logic [255:0] ring_line = '0, ring_oe = '0;

  always #2 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_master #(.DIV_HALF(3)) dut_i (
    .clk(clk), .rst(rst), .req_start(req_start), .req_rd(req_rd), .req_phy(req_phy),
    .req_arg(req_arg), .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    ring_line[rise_total % 256] = mdio_i;
    ring_oe[rise_total % 256]   = mdio_oe;
    rise_total = rise_total + 1;
  end

  always @(negedge mdc) begin
    int k;
    k = rise_total - t_base - (t_ext ? 65 : 0);
    if (t_rd && k == 47) begin
      phy_en = 1'b1; phy_bit = t_ta;
    end else if (t_rd && k >= 48 && k <= 63) begin
      phy_en = 1'b1; phy_bit = t_rdv[63 - k];
    end else begin
      phy_en = 1'b0; phy_bit = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [129:0] act, input logic [129:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] fr(input logic ext, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] f, input logic [1:0] ta,
      input logic [15:0] d);
    return {32'hFFFF_FFFF, ext ? 2'b00 : 2'b01, op, phy, f, ta, d};
  endfunction

  task automatic run(input bit rd, input logic [4:0] phy, input logic [31:0] arg,
                     input logic [15:0] wd, input logic ta, input logic [15:0] rdv,
                     input bit poke);
    logic         ext;
    logic [63:0]  acc, oe64;
    logic [129:0] exp_line, exp_oe, got_line, got_oe;
    int           nbits, cyc, dn;
    logic [15:0]  got_rd;
    logic         got_er;
    string        tag;
    ext = arg[30];
    oe64 = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    if (ext) begin
      acc = fr(1'b1, rd ? 2'b11 : 2'b01, phy, arg[20:16], rd ? {1'b1, ta} : 2'b10, rd ? rdv : wd);
      exp_line = {fr(1'b1, 2'b00, phy, arg[20:16], 2'b10, arg[15:0]), 1'b1, acc, 1'b0};
      exp_oe   = {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, oe64, 1'b0};
      nbits = 129;
    end else begin
      acc = fr(1'b0, rd ? 2'b10 : 2'b01, phy, arg[4:0], rd ? {1'b1, ta} : 2'b10, rd ? rdv : wd);
      exp_line = {acc, 66'b0};
      exp_oe   = {oe64, 66'b0};
      nbits = 64;
    end
    @(negedge clk);
    t_ext = ext; t_rd = rd; t_ta = ta; t_rdv = rdv; t_base = rise_total;
    req_start = 1'b1; req_rd = rd; req_phy = phy; req_arg = arg; req_wdata = wd;
    @(negedge clk);
    req_start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R8", "busy mid-transfer", 130'(busy), 130'(1));
      req_start = 1'b1; req_rd = ~rd; req_arg = arg ^ 32'h4000_0013; req_phy = ~phy;
      @(negedge clk);
      req_start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    got_rd = rdata; got_er = err; dn = done ? 1 : 0;
    repeat (40) begin @(negedge clk); if (done) dn++; end
    got_line = '0; got_oe = '0;
    for (int i = 0; i < nbits; i++) begin
      got_line[129 - i] = ring_line[(t_base + i) % 256];
      got_oe[129 - i]   = ring_oe[(t_base + i) % 256];
    end
    tag = ext ? "R3" : (rd ? "R2" : "R4");
    chk(got_line[129:98] == 32'hFFFF_FFFF, "R1", "preamble", 130'(got_line[129:98]), 130'(32'hFFFF_FFFF));
    chk(got_line == exp_line, tag, "bit stream", got_line, exp_line);
    chk(got_oe == exp_oe, rd ? "R5" : "R9", "output enable", got_oe, exp_oe);
    chk(rise_total - t_base == nbits, "R7", "MDC cycle count", 130'(rise_total - t_base), 130'(nbits));
    chk(dn == 1, "R8", "done pulses", 130'(dn), 130'(1));
    chk(!busy && !mdc && !mdio_oe, "R9", "idle after done", 130'({busy, mdc, mdio_oe}), 130'(0));
    if (rd) begin
      chk(got_er == ta, "R6", "err flag", 130'(got_er), 130'(ta));
      chk(got_rd == (ta ? 16'hFFFF : rdv), ta ? "R6" : "R5", "rdata",
          130'(got_rd), 130'(ta ? 16'hFFFF : rdv));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t0, w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({mdc, mdio_oe, busy, done, err} == 5'b0, "R9", "reset state",
        130'({mdc, mdio_oe, busy, done, err}), 130'(0));
    // R7: MDC half period of DIV_HALF=3 clocks, measured on a short write
    @(negedge clk);
    req_start = 1'b1; req_rd = 1'b0; req_arg = 32'h0; req_phy = 5'h1; t_base = rise_total;
    @(negedge clk); req_start = 1'b0;
    while (!mdc) @(negedge clk);
    t0 = 0; while (mdc) begin @(negedge clk); t0++; end
    w = 0; while (!mdc) begin @(negedge clk); w++; end
    chk(t0 == 3 && w == 3, "R7", "MDC high/low clocks", 130'({t0[7:0], w[7:0]}), 130'(16'h0303));
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    // sweep of all four request kinds
    for (int p = 0; p < 32; p += 9) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a;
        logic [15:0] d;
        d = 16'hA5C3 ^ (16'h1 << (p % 16)) ^ 16'(k * 16'h1111);
        if (k >= 2) a = {1'b0, 1'b1, 9'h0, 5'(~p), 16'(16'h8001 << k) ^ 16'(p)};
        else        a = {27'h0, 5'((p * 7 + k) % 32)};
        run(k[0], 5'(p), a, d, 1'b0, ~d, 1'b0);
      end
    end
    // boundary field values and ignored argument bits
    run(1'b0, 5'h1F, 32'hBFFF_FFFF, 16'hFFFF, 1'b0, 16'h0, 1'b0);
    run(1'b1, 5'h00, 32'hBFFF_FFE0, 16'h0, 1'b0, 16'h0000, 1'b0);
    run(1'b0, 5'h1F, 32'hFFFF_FFFF, 16'h0000, 1'b0, 16'h0, 1'b0);
    run(1'b1, 5'h1F, 32'h401F_FFFF, 16'h0, 1'b0, 16'hFFFF, 1'b0);
    // bad turnaround on both styles
    run(1'b1, 5'h0A, 32'h0000_0005, 16'h0, 1'b1, 16'h1234, 1'b0);
    run(1'b1, 5'h0B, 32'h4003_00F0, 16'h0, 1'b1, 16'h0, 1'b0);
    // start strobe while busy is dropped
    run(1'b0, 5'h06, 32'h0000_000C, 16'h5A5A, 1'b0, 16'h0, 1'b1);
    t0 = rise_total;
    repeat (300) @(negedge clk);
    chk(rise_total == t0 && !busy, "R8", "no late start", 130'(rise_total - t0), 130'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule